// File: doc/BRIEF.md
# Tear-Free Position Byte Reader

This block lets a host with an 8-bit data path read a wider position count one byte at a time, and always get two bytes that belong to the same count. A snapshot register copies the position counter, which arrives on an input port, on every rising clock edge. A small inhibit controller freezes that register while a read is in progress. The controller looks at the byte-select and active-low output-enable inputs only on the falling clock edge. The frozen value is reached through a two-way byte multiplexer and a bus-drive flag that stands in for a three-state buffer.

A read goes in three steps. First the host enables the bus with select low, which freezes the snapshot and presents the upper byte. Next it raises select while the bus is still enabled, which presents the lower byte and arms the release. Last it disables the bus, and the snapshot starts following the counter again. A parameter narrows the snapshot to 12 bits, and the missing upper bits then read as zero. An asynchronous active-low reset clears the inhibit at once. Its release is synchronised to the rising edge.

Top module: `pos_snapshot_reader`

## Requirements
- R1: Select and output-enable are acted on only at the falling clock edge. An enable with select low that is applied just after a falling edge still lets the snapshot load the counter at the next rising edge.
- R2: Enable low with select low (step one), seen at a falling edge while the inhibit is clear, sets the inhibit. The snapshot then holds, and the bus shows its upper byte.
- R3: Enable low with select high (step two), seen at a falling edge while held, presents the lower byte of the same frozen snapshot. The inhibit stays set.
- R4: Enable high (step three), seen at a falling edge after step two, clears the inhibit. The snapshot loads the counter again from the next rising edge.
- R5: Enable low with select high, seen while the inhibit is clear (a lower-byte read with no upper-byte read before it), does not set the inhibit.
- R6: While the inhibit is clear, the snapshot takes the counter value at every rising clock edge.
- R7: The bus-drive output is high exactly when the output-enable input is low. Select high routes bits [7:0] to the data output and select low routes bits [15:8]. The data output is all zeros while the bus is not driven.
- R8: With the 12-bit snapshot, bits [7:4] of the upper byte always read as zero.
- R9: Reset low clears the inhibit and the snapshot at once, without waiting for a clock. After reset is released, the snapshot follows the counter.
- R10: After step one, enable high with no step two in between does not clear the inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The snapshot loads on the rising edge; select and enable are sampled on the falling edge. |
| rst_n | input | 1 | Active-low reset. It takes effect asynchronously, and its release is synchronised. |
| count_i | input | 16 | Position counter value. |
| sel_i | input | 1 | Byte select: 0 = upper byte, 1 = lower byte. |
| oe_n_i | input | 1 | Active-low output enable. |
| data_o | output | 8 | Selected byte. Zero while the bus is not driven. |
| bus_drive_o | output | 1 | High when the data bus is driven; low stands for high impedance. |

## Verification
The bench builds two copies side by side, one with the full 16-bit snapshot and one with the 12-bit snapshot, and drives both with the same stimulus. Every byte read is therefore checked against both the unmasked and the masked expected value. A sweep over 64 arithmetically generated counts runs the full three-step read, a lower-byte-only read and the tracking that follows for each count, and the counter changes between every step so that a snapshot that is not frozen would show up. Separate cases cover an enable applied just after a falling edge, an abandoned read that stops after step one, and a reset that arrives while the snapshot is held.

// File: rtl/pos_snapshot_pkg.sv
package pos_snapshot_pkg;
  typedef enum logic [1:0] {
    INH_FREE  = 2'd0,
    INH_HELD  = 2'd1,
    INH_DRAIN = 2'd2
  } inh_state_t;
endpackage

// File: rtl/pos_snapshot_rst_sync.sv
module pos_snapshot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/pos_snapshot_inhibit_fsm.sv
module pos_snapshot_inhibit_fsm
  import pos_snapshot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic oe_n_i,
  output logic inhibit_o
);
  inh_state_t state_q, state_d;

  // Next state: step one freezes, step two arms the release, step three releases.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      INH_FREE:  if (!oe_n_i && !sel_i) state_d = INH_HELD;
      INH_HELD:  if (!oe_n_i &&  sel_i) state_d = INH_DRAIN;
      INH_DRAIN: begin
        if (oe_n_i)      state_d = INH_FREE;
        else if (!sel_i) state_d = INH_HELD;
      end
      default:           state_d = INH_FREE;
    endcase
  end

  // Inputs are sampled on the falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= INH_FREE;
    else        state_q <= state_d;
  end

  assign inhibit_o = (state_q != INH_FREE);
endmodule

// File: rtl/pos_snapshot_latch.sv
module pos_snapshot_latch #(
  parameter int WORD_W  = 16,
  parameter int LATCH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [WORD_W-1:0] count_i,
  output logic [WORD_W-1:0] word_o
);
  logic [LATCH_W-1:0] snap_q;
  logic               load_en;

  assign load_en = !hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (load_en) snap_q <= count_i[LATCH_W-1:0];
  end

  generate
    if (LATCH_W < WORD_W) begin : g_narrow
      assign word_o = {{(WORD_W-LATCH_W){1'b0}}, snap_q};
    end else begin : g_full
      assign word_o = snap_q;
    end
  endgenerate
endmodule

// File: rtl/pos_snapshot_byte_mux.sv
module pos_snapshot_byte_mux #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] word_i,
  input  logic                sel_i,
  input  logic                oe_n_i,
  output logic [BYTE_W-1:0]   data_o,
  output logic                drive_o
);
  always_comb begin
    drive_o = !oe_n_i;
    if (!drive_o)   data_o = '0;
    else if (sel_i) data_o = word_i[BYTE_W-1:0];
    else            data_o = word_i[2*BYTE_W-1:BYTE_W];
  end
endmodule

// File: rtl/pos_snapshot_reader.sv
module pos_snapshot_reader #(
  parameter int BYTE_W     = 8,
  parameter int LATCH_W    = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BYTE_W-1:0] count_i,
  input  logic                sel_i,
  input  logic                oe_n_i,
  output logic [BYTE_W-1:0]   data_o,
  output logic                bus_drive_o
);
  // LATCH_W must lie in (BYTE_W, 2*BYTE_W].
  localparam int WORD_W = 2 * BYTE_W;

  logic              rst_sync_n;
  logic              inhibit;
  logic [WORD_W-1:0] latch_word;

  pos_snapshot_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pos_snapshot_inhibit_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_i     (sel_i),
    .oe_n_i    (oe_n_i),
    .inhibit_o (inhibit)
  );

  pos_snapshot_latch #(.WORD_W(WORD_W), .LATCH_W(LATCH_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hold_i  (inhibit),
    .count_i (count_i),
    .word_o  (latch_word)
  );

  pos_snapshot_byte_mux #(.BYTE_W(BYTE_W)) u_mux (
    .word_i  (latch_word),
    .sel_i   (sel_i),
    .oe_n_i  (oe_n_i),
    .data_o  (data_o),
    .drive_o (bus_drive_o)
  );
endmodule

// File: rtl/pos_snapshot_reader_chk.sv
module pos_snapshot_reader_chk #(
  parameter int BYTE_W  = 8,
  parameter int LATCH_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_sync_n,
  input logic                sel_i,
  input logic                oe_n_i,
  input logic [2*BYTE_W-1:0] count_i,
  input logic                inhibit,
  input logic [2*BYTE_W-1:0] latch_word,
  input logic [BYTE_W-1:0]   data_o,
  input logic                bus_drive_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [WORD_W-1:0] MASK = {WORD_W{1'b1}} >> (WORD_W - LATCH_W);

  p_step1_sets_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (!oe_n_i && !sel_i) |=> inhibit);

  p_held_freezes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(latch_word));

  p_enabled_keeps_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (inhibit && !oe_n_i) |=> inhibit);

  p_release_after_idle_r4: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(inhibit) |-> $past(oe_n_i));

  p_low_only_free_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (!inhibit && sel_i && !oe_n_i) |=> !inhibit);

  p_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && rst_sync_n) |=> (latch_word == $past(count_i & MASK)));

  p_idle_bus_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive_o |-> (data_o == '0));

  generate
    if (LATCH_W < WORD_W) begin : g_narrow_chk
      p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_o && !sel_i) |-> (data_o[BYTE_W-1:LATCH_W-BYTE_W] == '0));
    end
  endgenerate
endmodule

bind pos_snapshot_reader pos_snapshot_reader_chk #(
  .BYTE_W (BYTE_W),
  .LATCH_W(LATCH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .sel_i      (sel_i),
  .oe_n_i     (oe_n_i),
  .count_i    (count_i),
  .inhibit    (inhibit),
  .latch_word (latch_word),
  .data_o     (data_o),
  .bus_drive_o(bus_drive_o)
);

// File: tb/pos_snapshot_reader_tb.sv
module pos_snapshot_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt;
  logic        sel, oe_n;
  logic [7:0]  d16, d12;
  logic        drv16, drv12;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pos_snapshot_reader #(.LATCH_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .sel_i(sel), .oe_n_i(oe_n),
    .data_o(d16), .bus_drive_o(drv16));

  pos_snapshot_reader #(.LATCH_W(12)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .sel_i(sel), .oe_n_i(oe_n),
    .data_o(d12), .bus_drive_o(drv12));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic at_rise();
    @(posedge clk); #1;
  endtask

  task automatic at_fall();
    @(negedge clk); #2;
  endtask

  task automatic hi_both(input string tag, input logic [15:0] v);
    chk({tag, " w16 hi"}, d16, v[15:8]);
    chk({tag, " w12 hi R8"}, d12, {4'h0, v[11:8]});
  endtask

  task automatic lo_both(input string tag, input logic [15:0] v);
    chk({tag, " w16 lo"}, d16, v[7:0]);
    chk({tag, " w12 lo"}, d12, v[7:0]);
  endtask

  task automatic idle_both(input string tag);
    chk({tag, " drive16"}, {7'd0, drv16}, 8'd0);
    chk({tag, " drive12"}, {7'd0, drv12}, 8'd0);
    chk({tag, " data16"}, d16, 8'd0);
    chk({tag, " data12"}, d12, 8'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cnt = 16'hA5C3; sel = 1'b0; oe_n = 1'b1;
    #12;
    oe_n = 1'b0; #1;
    // R9 reset state, R7 drive follows enable
    hi_both("R9 reset", 16'h0000);
    chk("R7 drive on", {7'd0, drv16}, 8'd1);
    oe_n = 1'b1; #1;
    idle_both("R7 idle in reset");
    at_rise(); at_rise();
    rst_n = 1'b1;
    repeat (4) at_rise();

    for (int k = 0; k < 64; k++) begin
      logic [15:0] v, w, u;
      v = 16'(k * 16'h0F3D) ^ 16'(k << 9) ^ 16'h5A17;
      w = v ^ 16'hFFFF;
      u = v + 16'd1;
      cnt = v; oe_n = 1'b1; sel = 1'b0;
      at_rise();
      sel = 1'b0; oe_n = 1'b0;                // step one
      at_fall();
      hi_both("R2 step1", v);
      chk("R7 drive", {7'd0, drv16}, 8'd1);
      at_rise(); cnt = w;
      at_rise(); sel = 1'b1;                  // step two
      at_fall();
      lo_both("R3 step2", v);
      at_rise(); cnt = u;
      at_rise();
      lo_both("R3 still held", v);
      oe_n = 1'b1;                            // step three
      at_fall();
      idle_both("R7 idle");
      at_rise();                              // snapshot took u
      cnt = w; sel = 1'b1; oe_n = 1'b0;       // low-only read
      at_fall();
      lo_both("R4 resumed", u);
      at_rise();
      lo_both("R5 low-only no freeze", w);
      cnt = v;
      at_rise();
      lo_both("R6 tracking", v);
      oe_n = 1'b1;
      at_rise();
    end

    // R1: enable applied just after a falling edge; next rising edge still loads.
    cnt = 16'h1234;
    at_rise();
    @(negedge clk); #1;
    sel = 1'b0; oe_n = 1'b0; cnt = 16'hBEEF;
    at_fall();
    hi_both("R1 falling-edge sample", 16'hBEEF);
    at_rise(); sel = 1'b1; at_fall();
    lo_both("R1 low byte", 16'hBEEF);
    at_rise(); oe_n = 1'b1; at_rise(); at_rise();

    // R10: abandoned read after step one stays frozen.
    cnt = 16'h7E81;
    at_rise();
    sel = 1'b0; oe_n = 1'b0;
    at_fall();
    hi_both("R10 step1", 16'h7E81);
    at_rise(); oe_n = 1'b1; cnt = 16'h0C3F;
    repeat (3) at_rise();
    sel = 1'b1; oe_n = 1'b0;
    at_fall();
    lo_both("R10 still frozen", 16'h7E81);

    // R9: reset while held clears at once, then tracking resumes.
    at_rise();
    #2 rst_n = 1'b0; sel = 1'b0; oe_n = 1'b0;
    #1;
    hi_both("R9 async clear", 16'h0000);
    oe_n = 1'b1;
    at_rise(); at_rise();
    rst_n = 1'b1; cnt = 16'hD00D;
    repeat (4) at_rise();
    sel = 1'b1; oe_n = 1'b0;
    at_fall();
    lo_both("R9 tracking after reset", 16'hD00D);
    at_rise();
    cnt = 16'h4A4A;
    at_rise();
    lo_both("R9 R6 follows", 16'h4A4A);
    oe_n = 1'b1;
    at_rise();
    summary();
  end
endmodule